// File: doc/BRIEF.md
# Loop Iteration Sequencer

This block is a small control state machine that steps a separate datapath through repeated passes of a loop body. A one-cycle start pulse launches a run. In counted mode the run makes a fixed number of passes, given as a trip count at start. In conditional mode the run keeps making passes until a stop input is seen high during a body cycle. The datapath follows the run through two strobes. An optional init strobe lasts one cycle and loads the loop-carried registers. A body enable strobe lasts one cycle per pass.

Each pass is one body cycle followed by two fixed overhead cycles. The run then either starts the next pass or ends with a one-cycle done pulse. An iteration index goes with each body strobe. The index saturates at its largest positive signed value and never wraps. The datapath itself is outside this block.

Top module: `loop_sequencer`

## Requirements
- R1: A synchronous active-high reset makes busy, done, init_stb and body_stb low and clears iter_idx to 0 in the cycle after the reset edge.
- R2: In counted mode (cond_mode = 0), a run makes exactly trip_count body strobes, and the stop input has no effect.
- R3: In conditional mode (cond_mode = 1), the run ends after the first body cycle in which stop_req is high. The body therefore runs at least once, and trip_count is ignored.
- R4: Consecutive body strobes are exactly three cycles apart, which leaves two cycles with no strobe between passes.
- R5: If init_req is high at start, init_stb is high for exactly the first cycle after the start edge, and the first body strobe comes one cycle later. If init_req is low, the first body strobe is in the first cycle after start and init_stb never rises.
- R6: A counted run with trip_count = 0 makes no body strobe. The done pulse comes in the first cycle after start, or in the second cycle when init was requested.
- R7: Start clears iter_idx to 0. During the k-th body strobe (counting from 0), iter_idx equals k. After the run, iter_idx holds the number of passes made until the next start.
- R8: iter_idx is treated as an IDX_W-bit signed value (default 32 bits). It saturates at 2^(IDX_W-1)-1 and never becomes negative.
- R9: Let the start edge end cycle 0. The done pulse lasts one cycle and falls in cycle i+3n+1, where i is 1 if init was requested and 0 otherwise, and n ≥ 1 is the number of passes. Busy is high from cycle 1 up to the cycle before done, and low during done.
- R10: A start pulse seen while busy or during the done cycle is ignored. The current run keeps its timing, and the block returns to idle after done.
- R11: stop_req is sampled only in body cycles. Its value during init and gap cycles does not change the number of passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted only when idle |
| cond_mode | input | 1 | 0 = counted mode, 1 = conditional mode |
| init_req | input | 1 | Request one init cycle before the first pass |
| trip_count | input | CNT_W | Number of passes in counted mode |
| stop_req | input | 1 | Stop condition, sampled in body cycles |
| init_stb | output | 1 | One-cycle strobe that loads loop-carried state |
| body_stb | output | 1 | One-cycle body enable per pass |
| iter_idx | output | IDX_W | Saturating signed iteration index |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The properties assume that reset is held on the first clock edge, so that every $past term refers to a defined state. They also assume that a counted run never has more passes than the index can represent, unless saturation is the thing under test. The stimulus meets both conditions. It applies reset before the first start. Its trip counts stay small, except on a narrow-index copy of the block, where saturation is reached on purpose. The bench drives stop_req from the block's own outputs, high during the body cycle with the chosen index. In some runs it also holds stop_req high in every non-body cycle, which checks that those values are ignored.

// File: rtl/loop_sequencer.sv
module loop_sequencer #(
  parameter int IDX_W = 32,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cond_mode,
  input  logic             init_req,
  input  logic [CNT_W-1:0] trip_count,
  input  logic             stop_req,
  output logic             init_stb,
  output logic             body_stb,
  output logic [IDX_W-1:0] iter_idx,
  output logic             busy,
  output logic             done
);

  localparam logic [IDX_W-1:0] IDX_MAX = {1'b0, {(IDX_W-1){1'b1}}};

  typedef enum logic [2:0] {
    S_IDLE, S_INIT, S_BODY, S_GAP1, S_GAP2, S_DONE
  } state_t;

  state_t           state, nxt;
  logic             mode_q;
  logic             halt_q;
  logic [CNT_W-1:0] left_q;
  logic             empty_now;
  logic             empty_q;
  logic             finish;

  assign empty_now = !cond_mode && (trip_count == '0);
  assign empty_q   = !mode_q && (left_q == '0);
  assign finish    = mode_q ? halt_q : (left_q == '0);

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:  if (start) nxt = init_req ? S_INIT : (empty_now ? S_DONE : S_BODY);
      S_INIT:  nxt = empty_q ? S_DONE : S_BODY;
      S_BODY:  nxt = S_GAP1;
      S_GAP1:  nxt = S_GAP2;
      S_GAP2:  nxt = finish ? S_DONE : S_BODY;
      S_DONE:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      mode_q   <= 1'b0;
      halt_q   <= 1'b0;
      left_q   <= '0;
      iter_idx <= '0;
    end else begin
      state <= nxt;
      if (state == S_IDLE && start) begin
        mode_q   <= cond_mode;
        halt_q   <= 1'b0;
        left_q   <= trip_count;
        iter_idx <= '0;
      end else if (state == S_BODY) begin
        halt_q <= stop_req;
        if (!mode_q) left_q <= left_q - CNT_W'(1);
        if (iter_idx != IDX_MAX) iter_idx <= iter_idx + IDX_W'(1);
      end
    end
  end

  assign init_stb = (state == S_INIT);
  assign body_stb = (state == S_BODY);
  assign done     = (state == S_DONE);
  assign busy     = (state == S_INIT) || (state == S_BODY) ||
                    (state == S_GAP1) || (state == S_GAP2);

endmodule

module loop_sequencer_chk #(
  parameter int IDX_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             init_stb,
  input logic             body_stb,
  input logic [IDX_W-1:0] iter_idx,
  input logic             busy,
  input logic             done
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !done && !body_stb && !init_stb && iter_idx == '0));

  // R4
  body_single_chk: assert property (@(posedge clk) disable iff (rst)
    body_stb |=> !body_stb);

  // R4
  body_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $past(body_stb) |-> !body_stb);

  // R5
  init_next_chk: assert property (@(posedge clk) disable iff (rst)
    init_stb |=> (body_stb || done));

  // R7
  idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !body_stb) |=> $stable(iter_idx));

  // R8
  idx_sign_chk: assert property (@(posedge clk) disable iff (rst)
    !iter_idx[IDX_W-1]);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  // R10
  done_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({init_stb, body_stb, done}));

endmodule

bind loop_sequencer loop_sequencer_chk #(.IDX_W(IDX_W)) chk (
  .clk(clk), .rst(rst), .init_stb(init_stb), .body_stb(body_stb),
  .iter_idx(iter_idx), .busy(busy), .done(done)
);

// File: tb/loop_sequencer_test.sv
module loop_sequencer_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        cond_mode = 1'b0;
  logic        init_req = 1'b0;
  logic        noise = 1'b0;
  logic [31:0] trip = '0;
  logic [7:0]  stop_at = '0;
  logic        stop_req;
  logic        init_stb, body_stb, busy, done;
  logic [31:0] iter_idx;

  logic        s_start = 1'b0;
  logic        s_init, s_body, s_busy, s_done;
  logic [3:0]  s_idx;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  assign stop_req = body_stb ? (iter_idx == 32'(stop_at)) : noise;

  loop_sequencer uut (
    .clk(clk), .rst(rst), .start(start), .cond_mode(cond_mode),
    .init_req(init_req), .trip_count(trip), .stop_req(stop_req),
    .init_stb(init_stb), .body_stb(body_stb), .iter_idx(iter_idx),
    .busy(busy), .done(done)
  );

  loop_sequencer #(.IDX_W(4), .CNT_W(8)) uut_small (
    .clk(clk), .rst(rst), .start(s_start), .cond_mode(1'b0),
    .init_req(1'b0), .trip_count(8'd10), .stop_req(1'b0),
    .init_stb(s_init), .body_stb(s_body), .iter_idx(s_idx),
    .busy(s_busy), .done(s_done)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // fields: [19] cond_mode, [18] init_req, [17] noise, [16] restart, [15:8] trip, [7:0] stop_at
  localparam logic [19:0] VEC [0:8] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 8'd3, 8'd0},
    {1'b0, 1'b1, 1'b0, 1'b0, 8'd5, 8'd0},
    {1'b0, 1'b0, 1'b1, 1'b1, 8'd4, 8'd0},
    {1'b0, 1'b0, 1'b0, 1'b0, 8'd0, 8'd0},
    {1'b0, 1'b1, 1'b0, 1'b0, 8'd0, 8'd0},
    {1'b1, 1'b0, 1'b0, 1'b0, 8'd0, 8'd0},
    {1'b1, 1'b1, 1'b1, 1'b0, 8'd9, 8'd4},
    {1'b1, 1'b0, 1'b0, 1'b1, 8'd2, 8'd6},
    {1'b0, 1'b0, 1'b0, 1'b0, 8'd1, 8'd0}
  };

  task automatic run_vec(input logic [19:0] v);
    int n, icyc, dcyc, bodies, inits, last_body, done_at, done_cnt;
    int idx_err, gap_err, busy_err, init_err;
    logic restart;
    string cnt_req;
    cond_mode = v[19];
    init_req  = v[18];
    noise     = v[17];
    restart   = v[16];
    trip      = 32'(v[15:8]);
    stop_at   = v[7:0];
    start     = 1'b1;
    n    = cond_mode ? int'(stop_at) + 1 : int'(trip);
    icyc = init_req ? 1 : 0;
    dcyc = (n == 0) ? icyc + 1 : icyc + 3 * n + 1;
    bodies = 0; inits = 0; last_body = 0; done_at = -1; done_cnt = 0;
    idx_err = 0; gap_err = 0; busy_err = 0; init_err = 0;
    for (int c = 1; c <= dcyc + 3; c++) begin
      @(negedge clk);
      start = restart && (c == 2 || c == dcyc);
      if (init_stb) begin
        inits++;
        if (c != 1) init_err++;
      end
      if (body_stb) begin
        if (iter_idx != 32'(bodies)) idx_err++;
        if (bodies == 0 && c != icyc + 1) init_err++;
        if (bodies > 0 && c - last_body != 3) gap_err++;
        last_body = c;
        bodies++;
      end
      if (busy != (c < dcyc)) busy_err++;
      if (done) begin
        done_cnt++;
        if (done_at < 0) done_at = c;
        check("R7 index at done", longint'(iter_idx), longint'(n));
      end
    end
    start = 1'b0;
    cnt_req = (n == 0) ? "R6 zero trip bodies" :
              (cond_mode ? (noise ? "R11 stop ignored outside body" : "R3 conditional bodies")
                         : (noise ? "R11 counted ignores stop" : "R2 counted bodies"));
    check(cnt_req, bodies, n);
    check("R5 init strobe count", inits, icyc);
    check("R5 init placement", init_err, 0);
    check(restart ? "R10 done cycle with extra start" : "R9 done cycle", done_at, dcyc);
    check("R9 done pulse count", done_cnt, 1);
    check("R9 busy window", busy_err, 0);
    check("R4 body spacing", gap_err, 0);
    check("R7 index during body", idx_err, 0);
    check("R7 index held in idle", longint'(iter_idx), longint'(n));
    check("R10 idle after run", busy, 0);
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy in reset", busy, 0);
    check("R1 done in reset", done, 0);
    check("R1 body_stb in reset", body_stb, 0);
    check("R1 index in reset", longint'(iter_idx), 0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < 9; i++) run_vec(VEC[i]);

    // R1 reset in the middle of a run
    cond_mode = 1'b0; init_req = 1'b0; noise = 1'b0; trip = 32'd5; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 busy after mid-run reset", busy, 0);
    check("R1 index after mid-run reset", longint'(iter_idx), 0);
    check("R1 body_stb after mid-run reset", body_stb, 0);
    rst = 1'b0;
    @(negedge clk);

    // R8 saturation on a 4-bit index: 10 passes, index 0..7 then 7
    s_start = 1'b1;
    k = 0;
    for (int c = 1; c <= 40; c++) begin
      @(negedge clk);
      s_start = 1'b0;
      if (s_body) begin
        check("R8 saturating index", longint'(s_idx), longint'((k > 7) ? 7 : k));
        k++;
      end
      if (s_done) check("R8 index at done saturated", longint'(s_idx), 7);
    end
    check("R8 pass count with saturation", k, 10);
    check("R8 index never negative", s_idx[3], 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule